// File: doc/BRIEF.md
# Serially programmed clock fanout controller

This block is the digital control logic of a one-to-ten clock fanout. A slow control clock shifts an eleven-bit configuration word in from a serial input. A twelfth control clock pulse commits the word to a control register. Ten bits of the register each gate one clock output. The remaining bit chooses which of two source clocks feeds the enabled outputs. Once a word is committed, the configuration is locked until the block is cleared.

A mode input chooses between programmed operation and a fixed standard operation. In standard operation all ten outputs are driven and the serial input directly picks the source. Every control clock edge taken in standard operation also clears the sequencer, the shift register and the control register. A disabled output always sits at logic low. The output path is purely combinational from the source clocks. Only the configuration state is clocked by the control clock.

Top module: `fanout_ctrl`

## Requirements
- R1: A control clock edge with `rst_n` low clears the pulse counter, the shift register and the control register. Afterwards, in programmed mode, every output is low whatever the source levels.
- R2: On each control clock edge with `prog_en` high and fewer than 11 bits taken, `ser_in` enters stage 10 of the shift register and every stage k below 10 takes the old value of stage k+1.
- R3: After 11 shifts, the bit shifted in first sits in stage 0 and enables `clk_out[9]`. The bit shifted in as number k (counting from 0) enables `clk_out[9-k]` for k up to 9. The eleventh bit (stage 10) is the source select.
- R4: The twelfth control clock pulse with `prog_en` high copies the shift register into the control register. Before that pulse the outputs keep their earlier state, which is all low after a clear.
- R5: After the commit, further control clock pulses in programmed mode change neither the shift register nor the control register, so the outputs do not change until a clear.
- R6: A control clock edge with `prog_en` low clears the pulse counter, the shift register and the control register. This also discards a partly shifted word.
- R7: While `prog_en` is low, all ten outputs follow `src0` when `ser_in` is 0 and follow `src1` when `ser_in` is 1. The control register has no effect.
- R8: While `prog_en` is high, an output whose enable bit is 1 follows `src0` when the select bit is 0 and follows `src1` when it is 1. An output whose enable bit is 0 is held low.
- R9: After a clear by `prog_en` low, a new word can be shifted in and committed exactly as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ck | input | 1 | Control clock for the shift register, the counter and the control register |
| rst_n | input | 1 | Active-low reset, sampled on `ck` |
| prog_en | input | 1 | 1 selects programmed mode; 0 selects standard mode and clears the state on each `ck` edge |
| ser_in | input | 1 | Serial configuration data in programmed mode; source select in standard mode |
| src0 | input | 1 | Source clock 0 |
| src1 | input | 1 | Source clock 1 |
| clk_out | output | 10 | Gated fanout outputs |

## Verification
The configuration results are due on the control clock edge: a committed word shows at the outputs right after the twelfth edge, and a clear shows right after the edge that samples `prog_en` low. The bench drives each input one time unit after a rising edge and samples just before the next drive. Every register result is therefore read a full edge after the stimulus that caused it. The output selection has no register in its path, so source and select changes are checked one time unit after they are applied, with no clock edge in between. This confirms that those results do not wait for a clock.

// File: rtl/fanout_pkg.sv
// Shared constants and types for the clock fanout controller.
// Assumes the configuration word is one enable bit per output plus one select bit.
package fanout_pkg;

    // Phases of the programming sequence, decoded from the pulse counter.
    typedef enum logic [1:0] {
        PH_SHIFT  = 2'd0,
        PH_COMMIT = 2'd1,
        PH_LOCKED = 2'd2
    } prog_phase_t;

    localparam int DEFAULT_OUTPUTS = 10;

endpackage

// File: rtl/fo_sequencer.sv
// Pulse counter that tracks the shift, commit and locked phases.
// Assumes a clear (reset or standard mode) always restarts at the shift phase.
module fo_sequencer
    import fanout_pkg::*;
#(
    parameter int CFG_W = 11,
    localparam int CNT_W = $clog2(CFG_W + 2)
) (
    input  logic             ck,
    input  logic             rst_n,
    input  logic             prog_en,
    output logic             shift_en,
    output logic             commit_en,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_COMMIT = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] CNT_LOCK   = CNT_W'(CFG_W + 1);

    prog_phase_t phase;

    // Decode the phase from the counter value.
    always_comb begin
        if (cnt < CNT_COMMIT)       phase = PH_SHIFT;
        else if (cnt == CNT_COMMIT) phase = PH_COMMIT;
        else                        phase = PH_LOCKED;
    end

    assign shift_en  = prog_en && (phase == PH_SHIFT);
    assign commit_en = prog_en && (phase == PH_COMMIT);

    // Advance the counter until the locked value, clearing on reset or standard mode.
    always_ff @(posedge ck) begin
        if (!rst_n || !prog_en) begin
            cnt <= '0;
        end else if (phase != PH_LOCKED) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fo_shift_reg.sv
// Serial-in shift register: new bits enter the top stage and move toward stage 0.
// Assumes shift_en is already qualified by mode and phase.
module fo_shift_reg #(
    parameter int W = 11
) (
    input  logic         ck,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] q
);

    // Shift one bit in per enabled edge; clear on reset or clear request.
    always_ff @(posedge ck) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {ser_in, q[W-1:1]};
        end
    end

endmodule

// File: rtl/fo_ctrl_reg.sv
// Control register that takes the assembled word on a single commit edge.
// Assumes load fires at most once between clears.
module fo_ctrl_reg #(
    parameter int W = 11
) (
    input  logic         ck,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the word on commit; clear on reset or clear request.
    always_ff @(posedge ck) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fo_out_select.sv
// Combinational output gating and source selection for every fanout output.
// Assumes ctrl[NUM_OUT] is the select bit and ctrl[k] enables output NUM_OUT-1-k.
module fo_out_select #(
    parameter int NUM_OUT = 10,
    localparam int CFG_W = NUM_OUT + 1
) (
    input  logic               prog_en,
    input  logic               ser_in,
    input  logic               src0,
    input  logic               src1,
    input  logic [CFG_W-1:0]   ctrl,
    output logic [NUM_OUT-1:0] clk_out
);

    logic sel_src;

    // Choose the source: the serial pin in standard mode, the register select bit otherwise.
    always_comb begin
        if (!prog_en) sel_src = ser_in ? src1 : src0;
        else          sel_src = ctrl[NUM_OUT] ? src1 : src0;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        // Gate one output by its enable bit, or force it on in standard mode.
        always_comb begin
            clk_out[i] = sel_src & (!prog_en | ctrl[NUM_OUT-1-i]);
        end
    end

endmodule

// File: rtl/fanout_ctrl.sv
// Top of the clock fanout controller: sequencer, shift register, control register, output gating.
// Assumes ck is a slow control clock and src0/src1 are free-running clocks.
module fanout_ctrl #(
    parameter int NUM_OUT = 10
) (
    input  logic               ck,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic               ser_in,
    input  logic               src0,
    input  logic               src1,
    output logic [NUM_OUT-1:0] clk_out
);

    localparam int CFG_W = NUM_OUT + 1;
    localparam int CNT_W = $clog2(CFG_W + 2);

    logic             shift_en;
    logic             commit_en;
    logic             clr;
    logic [CNT_W-1:0] seq_cnt;
    logic [CFG_W-1:0] shift_q;
    logic [CFG_W-1:0] ctrl_q;

    assign clr = !prog_en;

    fo_sequencer #(.CFG_W(CFG_W)) u_seq (
        .ck        (ck),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .shift_en  (shift_en),
        .commit_en (commit_en),
        .cnt       (seq_cnt)
    );

    fo_shift_reg #(.W(CFG_W)) u_sr (
        .ck       (ck),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .q        (shift_q)
    );

    fo_ctrl_reg #(.W(CFG_W)) u_cr (
        .ck    (ck),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (commit_en),
        .d     (shift_q),
        .q     (ctrl_q)
    );

    fo_out_select #(.NUM_OUT(NUM_OUT)) u_sel (
        .prog_en (prog_en),
        .ser_in  (ser_in),
        .src0    (src0),
        .src1    (src1),
        .ctrl    (ctrl_q),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/fanout_ctrl_chk.sv
// Property checker for fanout_ctrl, attached by bind.
// Assumes it sees the internal counter, shift register and control register.
module fanout_ctrl_chk #(
    parameter int NUM_OUT = 10,
    localparam int CFG_W = NUM_OUT + 1,
    localparam int CNT_W = $clog2(CFG_W + 2)
) (
    input logic               ck,
    input logic               rst_n,
    input logic               prog_en,
    input logic               ser_in,
    input logic               src0,
    input logic               src1,
    input logic [NUM_OUT-1:0] clk_out,
    input logic [CNT_W-1:0]   cnt,
    input logic [CFG_W-1:0]   sr,
    input logic [CFG_W-1:0]   cr
);

    localparam logic [CNT_W-1:0] CNT_COMMIT = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] CNT_LOCK   = CNT_W'(CFG_W + 1);

    a_r1_reset_clears: assert property (@(posedge ck)
        !rst_n |=> (cnt == '0 && sr == '0 && cr == '0));

    a_r2_shift_in: assert property (@(posedge ck) disable iff (!rst_n)
        (prog_en && cnt < CNT_COMMIT) |=>
            (sr[CFG_W-1] == $past(ser_in) && sr[CFG_W-2:0] == $past(sr[CFG_W-1:1])));

    a_r4_commit_copies: assert property (@(posedge ck) disable iff (!rst_n)
        (prog_en && cnt == CNT_COMMIT) |=> (cr == $past(sr)));

    a_r5_locked_stable: assert property (@(posedge ck) disable iff (!rst_n)
        (prog_en && cnt == CNT_LOCK) |=> ($stable(cr) && $stable(sr) && cnt == CNT_LOCK));

    a_r6_std_clears: assert property (@(posedge ck) disable iff (!rst_n)
        !prog_en |=> (cnt == '0 && sr == '0 && cr == '0));

    a_r7_std_outputs: assert property (@(posedge ck) disable iff (!rst_n)
        !prog_en |-> (clk_out == (ser_in ? {NUM_OUT{src1}} : {NUM_OUT{src0}})));

    a_r8_all_disabled_low: assert property (@(posedge ck) disable iff (!rst_n)
        (prog_en && cr[NUM_OUT-1:0] == '0) |-> (clk_out == '0));

    a_r5_counter_bound: assert property (@(posedge ck) disable iff (!rst_n)
        cnt <= CNT_LOCK);

endmodule

bind fanout_ctrl fanout_ctrl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .ck      (ck),
    .rst_n   (rst_n),
    .prog_en (prog_en),
    .ser_in  (ser_in),
    .src0    (src0),
    .src1    (src1),
    .clk_out (clk_out),
    .cnt     (seq_cnt),
    .sr      (shift_q),
    .cr      (ctrl_q)
);

// File: tb/tb_fanout_ctrl.sv
// Directed bench for fanout_ctrl: one task per scenario, each checking its own results.
module tb_fanout_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic         ck = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_en = 1'b1;
    logic         ser_in = 1'b0;
    logic         src0 = 1'b0;
    logic         src1 = 1'b0;
    logic [N-1:0] clk_out;

    int checks = 0;
    int errors = 0;

    fanout_ctrl #(.NUM_OUT(N)) dut (
        .ck      (ck),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .ser_in  (ser_in),
        .src0    (src0),
        .src1    (src1),
        .clk_out (clk_out)
    );

    always #(CLK_PERIOD/2) ck = ~ck;

    task automatic tick();
        @(posedge ck);
        #1;
    endtask

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    // Expected programmed-mode output for word w and source levels.
    function automatic logic [N-1:0] exp_out(input logic [N:0] w, input logic s0, input logic s1);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = w[N-1-i];
        return (w[N] ? s1 : s0) ? m : '0;
    endfunction

    task automatic std_clear();
        prog_en = 1'b0; ser_in = 1'b0;
        tick();
        prog_en = 1'b1;
    endtask

    // Shift 11 bits first-to-last, optionally checking outputs before the commit edge, then commit.
    task automatic program_word(input logic [N:0] w, input bit pre_chk);
        prog_en = 1'b1;
        for (int i = 0; i <= N; i++) begin
            ser_in = w[i];
            tick();
        end
        if (pre_chk) begin
            src0 = 1'b1; src1 = 1'b1; #1;
            check("R4 no output before commit", clk_out, '0);
        end
        ser_in = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; prog_en = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        src0 = 1'b1; src1 = 1'b1; #1;
        check("R1 reset outputs low", clk_out, '0);
    endtask

    task automatic t_walking_one();
        for (int k = 0; k < N; k++) begin
            logic [N:0] w;
            std_clear();
            w = '0; w[k] = 1'b1;
            program_word(w, 1'b1);
            src0 = 1'b1; src1 = 1'b0; #1;
            check("R3 R2 walking one maps bit to output", clk_out, exp_out(w, 1'b1, 1'b0));
            src0 = 1'b0; src1 = 1'b1; #1;
            check("R8 select 0 ignores src1", clk_out, '0);
        end
    endtask

    task automatic t_select_bit();
        logic [N:0] w;
        w = {1'b1, 10'b1010011010};
        std_clear();
        program_word(w, 1'b0);
        src0 = 1'b0; src1 = 1'b1; #1;
        check("R8 select 1 routes src1", clk_out, exp_out(w, 1'b0, 1'b1));
        src0 = 1'b1; src1 = 1'b0; #1;
        check("R8 select 1 ignores src0", clk_out, '0);
    endtask

    task automatic t_locked();
        logic [N:0] w;
        logic [N:0] w2;
        w  = {1'b0, 10'b0011110000};
        w2 = {1'b1, 10'b1100001111};
        std_clear();
        program_word(w, 1'b0);
        program_word(w2, 1'b0);
        src0 = 1'b1; src1 = 1'b0; #1;
        check("R5 second word ignored src0", clk_out, exp_out(w, 1'b1, 1'b0));
        src0 = 1'b0; src1 = 1'b1; #1;
        check("R5 second word ignored src1", clk_out, '0);
    endtask

    task automatic t_standard();
        prog_en = 1'b0;
        ser_in = 1'b0; src0 = 1'b1; src1 = 1'b0; #1;
        check("R7 std sel0 src0 high", clk_out, '1);
        src0 = 1'b0; src1 = 1'b1; #1;
        check("R7 std sel0 src0 low", clk_out, '0);
        ser_in = 1'b1; #1;
        check("R7 std sel1 src1 high", clk_out, '1);
        src1 = 1'b0; src0 = 1'b1; #1;
        check("R7 std sel1 src1 low", clk_out, '0);
        tick();
        prog_en = 1'b1; ser_in = 1'b0; src0 = 1'b1; src1 = 1'b1; #1;
        check("R6 std edge cleared control", clk_out, '0);
    endtask

    task automatic t_partial_then_reprogram();
        logic [N:0] w;
        std_clear();
        prog_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ser_in = 1'b1;
            tick();
        end
        std_clear();
        w = {1'b0, 10'b0000000110};
        program_word(w, 1'b1);
        src0 = 1'b1; src1 = 1'b0; #1;
        check("R9 R6 reprogram after partial word", clk_out, exp_out(w, 1'b1, 1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_walking_one();
        t_select_bit();
        t_locked();
        t_standard();
        t_partial_then_reprogram();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule